// File: doc/BRIEF.md
# DDR3 Command Timing Monitor

This block watches the command pins of a DDR3 device from the controller's side, one sample per controller clock, and never drives the bus. Each sampled cycle is decoded into activate, precharge, read, write or "no effect". The block follows every bank as either idle or holding an open row. It keeps cycle counters per bank and for the whole device, and it judges each command against ordering rules and minimum-spacing rules. All spacing limits are parameters counted in clock cycles.

When a command breaks a rule, a sticky flag rises. A reason code and the offending bank are reported with it. The first reason seen is held until software-free logic around the block pulses a clear input. The block is meant for simulation and for on-chip monitoring. The data bus, refresh and mode-register contents are not examined.

A distance of d cycles means that the later command is sampled d clock edges after the earlier one. A rule with a limit T is broken when d < T, and a command at exactly d = T is legal.

Top module: `ddr3_cmd_monitor`

## Requirements
- R1: The command is decoded from {csN, rasN, casN, weN}, all active low, using these values: 0011 activate, 0010 precharge, 0100 write, 0101 read. Every other value, including 0111 and any value with csN high, leaves the bank state, the timers and the flag unchanged.
- R2: A read or write to an idle bank, and an activate to a bank that already has a row open, report code 1.
- R3: A read or write that comes less than T_RCD cycles after the activate of its bank reports code 2.
- R4: An activate that comes less than T_RP cycles after an explicit precharge closed that bank reports code 3.
- R5: A precharge that comes less than T_RAS cycles after the activate of an open bank reports code 4.
- R6: A precharge that comes less than T_RTP cycles after a read to that open bank reports code 5.
- R7: Two activates to the same bank less than T_RC cycles apart report code 6.
- R8: An activate that comes less than T_RRD cycles after an activate to a different bank reports code 7.
- R9: An activate reports code 8 when the FAW_ACTS-th previous activate, counted over any banks, lies less than T_FAW cycles back.
- R10: A read or write with addrAp high closes its bank. A following activate to that bank reports code 3 unless at least T_RTP+T_RP cycles (read) or T_WR_AP+T_RP cycles (write) have passed since the access.
- R11: A precharge with addrAp high targets all banks. A precharge that reaches an idle bank is legal and leaves that bank's timers as they were.
- R12: The flag, code and bank update on the clock edge that samples the offending command. After that they hold the first reason until clearFlag is high. clearFlag returns all three to zero, and a violation in the same cycle as clearFlag is captured.
- R13: When several rules break at once, one reason is reported. For an activate the order is code 1, then 3, 6, 7, 8. For a precharge, code 4 wins over code 5, and the lowest-numbered offending bank is the one reported.
- R14: After reset, the flag, code and bank are zero, every bank is idle, and all timers are expired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; the bus is sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| bank | input | BANK_W | Bank address |
| addrAp | input | 1 | Address line 10: auto-precharge on read/write, all banks on precharge |
| clearFlag | input | 1 | Clears the held violation |
| violFlag | output | 1 | Sticky violation flag |
| violCode | output | 4 | Reason: 1 state, 2 RCD, 3 RP, 4 RAS, 5 RTP, 6 RC, 7 RRD, 8 FAW |
| violBank | output | BANK_W | Bank of the held violation |

## Verification
The hardest case to reach is a spacing error that only the four-activate window catches. To get there, the bench has to place five activates inside the window while every other rule is met, and this needs a bank to be precharged and reopened inside that window. The bench runs with a reduced set of limits and four banks. It activates every bank at the minimum activate-to-activate spacing, precharges the first bank, and then sweeps the distance of the fifth activate across the window edge. Other sweeps walk each limit from below to beyond its boundary. One sweep places an activate after a read with auto-precharge so that, as the distance grows, the reported reason moves from precharge wait, to row cycle, to no violation.

// File: rtl/ddrmon_pkg.sv
package ddrmon_pkg;

  typedef enum logic [3:0] {
    VC_NONE  = 4'd0,
    VC_STATE = 4'd1,
    VC_RCD   = 4'd2,
    VC_RP    = 4'd3,
    VC_RAS   = 4'd4,
    VC_RTP   = 4'd5,
    VC_RC    = 4'd6,
    VC_RRD   = 4'd7,
    VC_FAW   = 4'd8
  } violCode_e;

  // strobes from the rule engine to the tracking datapath
  typedef struct packed {
    logic act;
    logic access;
    logic isRead;
    logic autoPre;
    logic pre;
    logic preAll;
  } cmdStrobe_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ddrmon_track.sv
module ddrmon_track
  import ddrmon_pkg::*;
#(
  parameter int BANK_W   = 3,
  parameter int CNT_W    = 6,
  parameter int T_RP     = 14,
  parameter int T_RTP    = 8,
  parameter int T_WR_AP  = 30,
  parameter int FAW_ACTS = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  cmdStrobe_t                     stb,
  input  logic [BANK_W-1:0]              cmdBank,
  output logic [(1<<BANK_W)-1:0]         bankOpen,
  output logic [(1<<BANK_W)-1:0][CNT_W-1:0] sinceAct,
  output logic [(1<<BANK_W)-1:0][CNT_W-1:0] sinceRd,
  output logic [(1<<BANK_W)-1:0][CNT_W-1:0] actWait,
  output logic [CNT_W-1:0]               sinceAnyAct,
  output logic [BANK_W-1:0]              lastActBank,
  output logic [CNT_W-1:0]               fawOldest
);
  localparam int NB = 1 << BANK_W;
  localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);
  localparam logic [CNT_W-1:0] W_PRE  = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] W_RDAP = CNT_W'(T_RTP + T_RP - 1);
  localparam logic [CNT_W-1:0] W_WRAP = CNT_W'(T_WR_AP + T_RP - 1);

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic hit;
    logic openR;
    logic [CNT_W-1:0] actCnt, rdCnt, waitCnt;
    assign hit = (cmdBank == BANK_W'(b));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        openR   <= 1'b0;
        actCnt  <= '1;
        rdCnt   <= '1;
        waitCnt <= '0;
      end else begin
        actCnt <= (stb.act && hit) ? ONE : ((actCnt == '1) ? actCnt : actCnt + 1'b1);
        rdCnt  <= (stb.access && stb.isRead && hit) ? ONE
                  : ((rdCnt == '1) ? rdCnt : rdCnt + 1'b1);
        if (stb.act && hit) begin
          openR <= 1'b1;
          if (waitCnt != '0) waitCnt <= waitCnt - 1'b1;
        end else if (stb.access && stb.autoPre && hit) begin
          openR   <= 1'b0;
          waitCnt <= stb.isRead ? W_RDAP : W_WRAP;
        end else if (stb.pre && (stb.preAll || hit) && openR) begin
          openR   <= 1'b0;
          waitCnt <= W_PRE;
        end else if (waitCnt != '0) begin
          waitCnt <= waitCnt - 1'b1;
        end
      end
    end

    assign bankOpen[b] = openR;
    assign sinceAct[b] = actCnt;
    assign sinceRd[b]  = rdCnt;
    assign actWait[b]  = waitCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceAnyAct <= '1;
      lastActBank <= '0;
    end else if (stb.act) begin
      sinceAnyAct <= ONE;
      lastActBank <= cmdBank;
    end else if (sinceAnyAct != '1) begin
      sinceAnyAct <= sinceAnyAct + 1'b1;
    end
  end

  // ages of the most recent activates, youngest first
  logic [FAW_ACTS-1:0][CNT_W-1:0] age;
  for (genvar i = 0; i < FAW_ACTS; i++) begin : g_age
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        age[i] <= '1;
      end else if (stb.act) begin
        if (i == 0) age[i] <= ONE;
        else        age[i] <= (age[(i == 0) ? 0 : i-1] == '1) ? '1 : age[(i == 0) ? 0 : i-1] + 1'b1;
      end else if (age[i] != '1) begin
        age[i] <= age[i] + 1'b1;
      end
    end
  end
  assign fawOldest = age[FAW_ACTS-1];

endmodule

// File: rtl/ddrmon_rules.sv
module ddrmon_rules
  import ddrmon_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int CNT_W  = 6,
  parameter int T_RCD  = 14,
  parameter int T_RAS  = 36,
  parameter int T_RTP  = 8,
  parameter int T_RC   = 50,
  parameter int T_RRD  = 6,
  parameter int T_FAW  = 27
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           csN,
  input  logic                           rasN,
  input  logic                           casN,
  input  logic                           weN,
  input  logic [BANK_W-1:0]              cmdBank,
  input  logic                           addrAp,
  input  logic                           clearFlag,
  input  logic [(1<<BANK_W)-1:0]         bankOpen,
  input  logic [(1<<BANK_W)-1:0][CNT_W-1:0] sinceAct,
  input  logic [(1<<BANK_W)-1:0][CNT_W-1:0] sinceRd,
  input  logic [(1<<BANK_W)-1:0][CNT_W-1:0] actWait,
  input  logic [CNT_W-1:0]               sinceAnyAct,
  input  logic [BANK_W-1:0]              lastActBank,
  input  logic [CNT_W-1:0]               fawOldest,
  output cmdStrobe_t                     stb,
  output logic                           violFlag,
  output logic [3:0]                     violCode,
  output logic [BANK_W-1:0]              violBank
);
  localparam int NB = 1 << BANK_W;
  localparam logic [CNT_W-1:0] L_RCD = CNT_W'(T_RCD);
  localparam logic [CNT_W-1:0] L_RAS = CNT_W'(T_RAS);
  localparam logic [CNT_W-1:0] L_RTP = CNT_W'(T_RTP);
  localparam logic [CNT_W-1:0] L_RC  = CNT_W'(T_RC);
  localparam logic [CNT_W-1:0] L_RRD = CNT_W'(T_RRD);
  localparam logic [CNT_W-1:0] L_FAW = CNT_W'(T_FAW);

  logic [3:0] pins;
  assign pins = {csN, rasN, casN, weN};

  always_comb begin
    stb         = '0;
    stb.act     = (pins == 4'b0011);
    stb.pre     = (pins == 4'b0010);
    stb.access  = (pins == 4'b0100) || (pins == 4'b0101);
    stb.isRead  = (pins == 4'b0101);
    stb.autoPre = stb.access && addrAp;
    stb.preAll  = stb.pre && addrAp;
  end

  violCode_e        newCode;
  logic [BANK_W-1:0] newBank;

  always_comb begin
    newCode = VC_NONE;
    newBank = cmdBank;
    if (stb.act) begin
      if (bankOpen[cmdBank])                                   newCode = VC_STATE;
      else if (actWait[cmdBank] != '0)                         newCode = VC_RP;
      else if (sinceAct[cmdBank] < L_RC)                       newCode = VC_RC;
      else if (lastActBank != cmdBank && sinceAnyAct < L_RRD)  newCode = VC_RRD;
      else if (fawOldest < L_FAW)                              newCode = VC_FAW;
    end else if (stb.access) begin
      if (!bankOpen[cmdBank])                                  newCode = VC_STATE;
      else if (sinceAct[cmdBank] < L_RCD)                      newCode = VC_RCD;
    end else if (stb.pre) begin
      // walk downward so the lowest offending bank is the one kept
      for (int i = NB - 1; i >= 0; i--) begin
        if ((stb.preAll || cmdBank == BANK_W'(i)) && bankOpen[i]) begin
          if (sinceAct[i] < L_RAS) begin
            newCode = VC_RAS;
            newBank = BANK_W'(i);
          end else if (sinceRd[i] < L_RTP) begin
            newCode = VC_RTP;
            newBank = BANK_W'(i);
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      violFlag <= 1'b0;
      violCode <= 4'd0;
      violBank <= '0;
    end else if (newCode != VC_NONE && (!violFlag || clearFlag)) begin
      violFlag <= 1'b1;
      violCode <= newCode;
      violBank <= newBank;
    end else if (clearFlag) begin
      violFlag <= 1'b0;
      violCode <= 4'd0;
      violBank <= '0;
    end
  end

endmodule

// File: rtl/ddr3_cmd_monitor.sv
module ddr3_cmd_monitor
  import ddrmon_pkg::*;
#(
  parameter int BANK_W   = 3,
  parameter int T_RCD    = 14,
  parameter int T_RP     = 14,
  parameter int T_RAS    = 36,
  parameter int T_RTP    = 8,
  parameter int T_RC     = 50,
  parameter int T_RRD    = 6,
  parameter int T_FAW    = 27,
  parameter int T_WR_AP  = 30,
  parameter int FAW_ACTS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic [BANK_W-1:0] bank,
  input  logic              addrAp,
  input  logic              clearFlag,
  output logic              violFlag,
  output logic [3:0]        violCode,
  output logic [BANK_W-1:0] violBank
);
  localparam int NB     = 1 << BANK_W;
  localparam int UP_MAX = maxOf(maxOf(maxOf(T_RC, T_RAS), maxOf(T_FAW, T_RCD)),
                                maxOf(T_RTP, T_RRD));
  localparam int DN_MAX = maxOf(T_RTP, T_WR_AP) + T_RP;
  localparam int CNT_W  = $clog2(maxOf(UP_MAX, DN_MAX) + 1);

  cmdStrobe_t                 cmdStb;
  logic [NB-1:0]              bankOpen;
  logic [NB-1:0][CNT_W-1:0]   sinceAct, sinceRd, actWait;
  logic [CNT_W-1:0]           sinceAnyAct, fawOldest;
  logic [BANK_W-1:0]          lastActBank;

  ddrmon_rules #(
    .BANK_W(BANK_W), .CNT_W(CNT_W), .T_RCD(T_RCD), .T_RAS(T_RAS),
    .T_RTP(T_RTP), .T_RC(T_RC), .T_RRD(T_RRD), .T_FAW(T_FAW)
  ) u_rules (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .cmdBank(bank), .addrAp(addrAp), .clearFlag(clearFlag),
    .bankOpen(bankOpen), .sinceAct(sinceAct), .sinceRd(sinceRd), .actWait(actWait),
    .sinceAnyAct(sinceAnyAct), .lastActBank(lastActBank), .fawOldest(fawOldest),
    .stb(cmdStb), .violFlag(violFlag), .violCode(violCode), .violBank(violBank)
  );

  ddrmon_track #(
    .BANK_W(BANK_W), .CNT_W(CNT_W), .T_RP(T_RP), .T_RTP(T_RTP),
    .T_WR_AP(T_WR_AP), .FAW_ACTS(FAW_ACTS)
  ) u_track (
    .clk(clk), .rstN(rstN), .stb(cmdStb), .cmdBank(bank),
    .bankOpen(bankOpen), .sinceAct(sinceAct), .sinceRd(sinceRd), .actWait(actWait),
    .sinceAnyAct(sinceAnyAct), .lastActBank(lastActBank), .fawOldest(fawOldest)
  );

endmodule

// File: rtl/ddrmon_checker.sv
module ddrmon_checker #(
  parameter int BANK_W = 3,
  parameter int T_RRD  = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              rasN,
  input logic              casN,
  input logic              weN,
  input logic [BANK_W-1:0] bank,
  input logic              clearFlag,
  input logic              violFlag,
  input logic [3:0]        violCode,
  input logic [BANK_W-1:0] violBank
);
  logic isAct;
  assign isAct = ({csN, rasN, casN, weN} == 4'b0011);

  // R12 / R14: with no held violation the report reads zero
  p_quiet_zero_r12: assert property (@(posedge clk) disable iff (!rstN)
    !violFlag |-> (violCode == 4'd0 && violBank == '0));

  // R12: a held reason does not change until cleared
  p_sticky_r12: assert property (@(posedge clk) disable iff (!rstN)
    (violFlag && !clearFlag) |=> (violFlag && $stable(violCode) && $stable(violBank)));

  // R12: clear during a deselected cycle always empties the report
  p_clear_r12: assert property (@(posedge clk) disable iff (!rstN)
    (clearFlag && csN) |=> !violFlag);

  // R1: deselect or no-operation never raises the flag
  p_nop_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!violFlag && (csN || {rasN, casN, weN} == 3'b111)) |=> !violFlag);

  // R13: a held reason is always one of the defined codes
  p_code_valid_r13: assert property (@(posedge clk) disable iff (!rstN)
    violFlag |-> (violCode >= 4'd1 && violCode <= 4'd8));

  // R8: activates to two banks on adjacent cycles cannot both be legal
  if (T_RRD > 1) begin : g_rrd
    p_adjacent_act_r8: assert property (@(posedge clk) disable iff (!rstN)
      (!violFlag && isAct && $past(isAct) && bank != $past(bank)) |=> violFlag);
  end

endmodule

bind ddr3_cmd_monitor ddrmon_checker #(.BANK_W(BANK_W), .T_RRD(T_RRD)) u_chk (.*);

// File: tb/sim_ddr3_cmd_monitor.sv
module sim_ddr3_cmd_monitor;
  localparam int BW = 2;
  localparam int RCD = 5, RP = 4, RAS = 9, RTP = 3, RC = 13, RRD = 2, FAW = 16, WRAP = 6;
  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_PRE = 4'b0010,
                         C_WR  = 4'b0100, C_RD  = 4'b0101;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b0, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic [BW-1:0] bank = '0;
  logic addrAp = 1'b0, clearFlag = 1'b0;
  logic violFlag;
  logic [3:0] violCode;
  logic [BW-1:0] violBank;
  int nChecks = 0, nFail = 0;

  always #4 clk = ~clk;

  ddr3_cmd_monitor #(
    .BANK_W(BW), .T_RCD(RCD), .T_RP(RP), .T_RAS(RAS), .T_RTP(RTP), .T_RC(RC),
    .T_RRD(RRD), .T_FAW(FAW), .T_WR_AP(WRAP), .FAW_ACTS(4)
  ) u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .bank(bank), .addrAp(addrAp), .clearFlag(clearFlag),
    .violFlag(violFlag), .violCode(violCode), .violBank(violBank)
  );

  task automatic issue(input logic [3:0] c, input int b, input logic ap);
    {csN, rasN, casN, weN} = c;
    bank = BW'(b);
    addrAp = ap;
    @(negedge clk);
    {csN, rasN, casN, weN} = C_NOP;
    addrAp = 1'b0;
    clearFlag = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    {csN, rasN, casN, weN} = C_NOP;
    clearFlag = 1'b0;
    idle(2);
    rstN = 1'b1;
    idle(1);
  endtask

  task automatic chk(input string req, input logic eF, input int eC, input int eB);
    nChecks++;
    if (violFlag !== eF || violCode !== 4'(eC) || violBank !== BW'(eB)) begin
      nFail++;
      $display("FAIL %s: got flag=%0d code=%0d bank=%0d, expected flag=%0d code=%0d bank=%0d",
               req, violFlag, violCode, violBank, eF, eC, eB);
    end
  endtask

  initial begin
    #(8 * 150000);
    nFail++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    // R14: reset state
    doReset();
    chk("R14", 1'b0, 0, 0);

    // R1: non-command encodings and deselected activate change nothing
    issue(4'b0000, 1, 1'b1); issue(4'b0001, 2, 1'b0); issue(4'b0110, 0, 1'b0);
    issue(4'b1011, 0, 1'b0); issue(4'b1101, 0, 1'b0); issue(C_NOP, 3, 1'b1);
    chk("R1", 1'b0, 0, 0);
    issue(C_RD, 0, 1'b0);
    chk("R1", 1'b1, 1, 0);

    // R2: access to idle bank, activate to open bank
    doReset(); issue(C_WR, 3, 1'b0);
    chk("R2", 1'b1, 1, 3);
    doReset(); issue(C_ACT, 2, 1'b0); idle(RC + 2); issue(C_ACT, 2, 1'b0);
    chk("R2", 1'b1, 1, 2);

    // R3: activate to read/write distance sweep
    for (int d = 1; d <= RCD + 2; d++) begin
      doReset(); issue(C_ACT, 1, 1'b0); idle(d - 1);
      issue((d % 2) ? C_WR : C_RD, 1, 1'b0);
      chk("R3", d < RCD, (d < RCD) ? 2 : 0, (d < RCD) ? 1 : 0);
    end

    // R4 and R13: precharge to activate sweep (row cycle also short, RP wins)
    for (int d = 1; d <= RP + 2; d++) begin
      doReset(); issue(C_ACT, 2, 1'b0); idle(RAS - 1); issue(C_PRE, 2, 1'b0);
      idle(d - 1); issue(C_ACT, 2, 1'b0);
      chk("R4", d < RP, (d < RP) ? 3 : 0, (d < RP) ? 2 : 0);
    end

    // R5: activate to precharge sweep
    for (int d = 1; d <= RAS + 2; d++) begin
      doReset(); issue(C_ACT, 3, 1'b0); idle(d - 1); issue(C_PRE, 3, 1'b0);
      chk("R5", d < RAS, (d < RAS) ? 4 : 0, (d < RAS) ? 3 : 0);
    end

    // R6: read to precharge sweep
    for (int d = 1; d <= RTP + 2; d++) begin
      doReset(); issue(C_ACT, 1, 1'b0); idle(RAS - 1); issue(C_RD, 1, 1'b0);
      idle(d - 1); issue(C_PRE, 1, 1'b0);
      chk("R6", d < RTP, (d < RTP) ? 5 : 0, (d < RTP) ? 1 : 0);
    end

    // R7 and R10: read with auto-precharge, reason moves RP -> RC -> none
    for (int k = RTP + RP - 2; k <= RC - RCD + 1; k++) begin
      int e;
      doReset(); issue(C_ACT, 0, 1'b0); idle(RCD - 1); issue(C_RD, 0, 1'b1);
      idle(k - 1); issue(C_ACT, 0, 1'b0);
      e = (k < RTP + RP) ? 3 : ((RCD + k < RC) ? 6 : 0);
      chk("R7", e != 0, e, 0);
    end

    // R10: write with auto-precharge wait sweep
    for (int k = WRAP + RP - 2; k <= WRAP + RP + 1; k++) begin
      doReset(); issue(C_ACT, 2, 1'b0); idle(RCD - 1); issue(C_WR, 2, 1'b1);
      idle(k - 1); issue(C_ACT, 2, 1'b0);
      chk("R10", k < WRAP + RP, (k < WRAP + RP) ? 3 : 0, (k < WRAP + RP) ? 2 : 0);
    end

    // R8: activate to different bank sweep
    for (int d = 1; d <= RRD + 2; d++) begin
      doReset(); issue(C_ACT, 0, 1'b0); idle(d - 1); issue(C_ACT, 3, 1'b0);
      chk("R8", d < RRD, (d < RRD) ? 7 : 0, (d < RRD) ? 3 : 0);
    end

    // R9: fifth activate inside the window
    for (int d = 13; d <= FAW + 1; d++) begin
      doReset();
      issue(C_ACT, 0, 1'b0); idle(1); issue(C_ACT, 1, 1'b0); idle(1);
      issue(C_ACT, 2, 1'b0); idle(1); issue(C_ACT, 3, 1'b0); idle(2);
      issue(C_PRE, 0, 1'b0);          // at distance 9 from the first activate
      idle(d - 10); issue(C_ACT, 0, 1'b0);
      chk("R9", d < FAW, (d < FAW) ? 8 : 0, 0);
    end

    // R11 and R13: precharge all, lowest offending bank reported
    doReset(); issue(C_ACT, 0, 1'b0); idle(1); issue(C_ACT, 1, 1'b0); idle(6);
    issue(C_PRE, 3, 1'b1);
    chk("R13", 1'b1, 4, 1);
    doReset(); issue(C_ACT, 0, 1'b0); idle(1); issue(C_ACT, 1, 1'b0); idle(8);
    issue(C_PRE, 0, 1'b1);
    chk("R11", 1'b0, 0, 0);
    idle(RP - 1); issue(C_ACT, 1, 1'b0);
    chk("R11", 1'b0, 0, 0);
    idle(2); issue(C_RD, 0, 1'b0);
    chk("R11", 1'b1, 1, 0);

    // R11: precharge to idle bank is legal and loads no wait
    doReset(); issue(C_PRE, 2, 1'b0);
    chk("R11", 1'b0, 0, 0);
    issue(C_ACT, 2, 1'b0);
    chk("R11", 1'b0, 0, 0);

    // R12: first reason held, clear, clear with simultaneous violation
    doReset(); issue(C_RD, 1, 1'b0);
    chk("R12", 1'b1, 1, 1);
    issue(C_ACT, 2, 1'b0); issue(C_RD, 2, 1'b0);
    chk("R12", 1'b1, 1, 1);
    clearFlag = 1'b1; issue(C_NOP, 0, 1'b0);
    chk("R12", 1'b0, 0, 0);
    clearFlag = 1'b1; issue(C_ACT, 2, 1'b0);
    chk("R12", 1'b1, 1, 2);
    clearFlag = 1'b1; issue(C_WR, 3, 1'b0);
    chk("R12", 1'b1, 1, 3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule